// File: doc/BRIEF.md
# FEAC Code Validator with Interrupts

This block is the receive-side qualifier for Far-End Alarm and Control codes. An upstream extractor hands it one 6-bit codeword at a time, marked by a one-cycle strobe. The block accepts a code as valid only after it has arrived in an unbroken run of identical codewords. It then drops that code once too many of the recent codewords disagree with it.

Software sees the result through two byte-wide registers on a simple synchronous bus. The code register holds the current validated code. The control/status register carries a live valid flag, two interrupt enables and two sticky event bits. The event bits record "code validated" and "code removed", and reading the register clears them. A level interrupt output combines each event bit with its enable.

Top module: `feac_rx_validator`

## Requirements
- R1: After reset, reads of address 0x16 and 0x17 return 0x00, and irq_o is low.
- R2: When no code is validated, 10 consecutive strobed codewords carrying the same 6-bit value validate that value. The valid flag (bit 4 of 0x17) becomes 1, the validate event bit (bit 0 of 0x17) becomes 1, and the code register holds the value. Nine such codewords do not validate.
- R3: A codeword that differs from the current run ends that run. The differing codeword counts as the first codeword of a new run.
- R4: While a code is validated, every strobed codeword is compared with it. The code is removed at the codeword that makes 3 of the last 10 codewords differ from it. Mismatches that have slid out of the 10-codeword window do not count. On removal, bit 4 of 0x17 becomes 0, the code register reads 0x00, and the remove event bit (bit 2 of 0x17) becomes 1.
- R5: Validation clears the mismatch window. After a removal, counting of runs starts again from zero with the next strobed codeword; the codeword that caused the removal does not count.
- R6: Address 0x16 returns the validated code in bits 6:1, with bits 7 and 0 reading 0. Bits 7:5 of 0x17 read 0.
- R7: A read (bus_en_i=1, bus_we_i=0) returns its data on bus_rdata_o one cycle after the read cycle. A read of 0x17 returns the value held before the read, then clears bits 0 and 2.
- R8: If an event occurs in the same cycle as a read of 0x17, that read returns the old value and the event bit stays set.
- R9: A write to 0x17 changes only bit 3 (remove interrupt enable) and bit 1 (validate interrupt enable). A write to 0x16 has no effect.
- R10: irq_o is high exactly while (bit 0 and bit 1) or (bit 2 and bit 3) of 0x17 are both 1.
- R11: Without a strobe, the validator state is unchanged. Further copies of the already validated code do not raise another validate event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cw_valid_i | input | 1 | Codeword strobe |
| cw_code_i | input | 6 | Received 6-bit codeword |
| bus_en_i | input | 1 | Bus access this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, one cycle after the read |
| irq_o | output | 1 | Level interrupt |

## Verification
Validation and removal take effect at the clock edge that samples the deciding strobe. The register contents and irq_o therefore change in the cycle after that strobe, and read data returns one edge after the read cycle. The bench drives every input at a falling edge and samples outputs at the next falling edge, which is one full edge later. A bench-side model updates at that same point, so every comparison lines up with the cycle in which the result is due. The same-cycle case, where an event and a status read fall in one cycle, is driven as a single bus cycle to test the set-priority rule.

// File: rtl/feac_pkg.sv
package feac_pkg;
  localparam int unsigned CODE_W = 6;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_CODE = 8'h16;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 8'h17;

  // status register bit positions (software decodes these)
  localparam int unsigned BIT_VAL_ST = 0;
  localparam int unsigned BIT_VAL_EN = 1;
  localparam int unsigned BIT_REM_ST = 2;
  localparam int unsigned BIT_REM_EN = 3;
  localparam int unsigned BIT_VALID  = 4;

  typedef struct packed {
    logic validated;
    logic removed;
  } feac_evt_t;
endpackage

// File: rtl/feac_mismatch_window.sv
module feac_mismatch_window #(
  parameter int unsigned WIN_LEN = 10,
  parameter int unsigned THRESH  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic shift_i,
  input  logic miss_i,
  output logic remove_o
);
  localparam int unsigned CNT_W = $clog2(WIN_LEN + 1);

  logic [WIN_LEN-1:0] win_q, win_next;
  logic [CNT_W-1:0]   psum [WIN_LEN+1];

  generate
    if (WIN_LEN == 1) begin : g_single
      assign win_next = miss_i;
    end else begin : g_multi
      assign win_next = {win_q[WIN_LEN-2:0], miss_i};
    end
  endgenerate

  assign psum[0] = '0;
  for (genvar i = 0; i < WIN_LEN; i++) begin : g_pop
    assign psum[i+1] = psum[i] + CNT_W'(win_next[i]);
  end

  assign remove_o = shift_i && (psum[WIN_LEN] >= CNT_W'(THRESH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  win_q <= '0;
    else if (clear_i || remove_o) win_q <= '0;
    else if (shift_i)             win_q <= win_next;
  end
endmodule

// File: rtl/feac_qualifier.sv
module feac_qualifier
  import feac_pkg::*;
#(
  parameter int unsigned RUN_LEN = 10,
  parameter int unsigned WIN_LEN = 10,
  parameter int unsigned THRESH  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cw_valid_i,
  input  logic [CODE_W-1:0] cw_code_i,
  output logic              code_valid_o,
  output logic [CODE_W-1:0] code_o,
  output feac_evt_t         evt_o
);
  localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);

  logic              valid_q;
  logic [CODE_W-1:0] code_q, cand_q;
  logic [CNT_W-1:0]  run_q, run_next;
  logic              same, val_evt, rem_evt, miss;

  assign same     = (run_q != '0) && (cw_code_i == cand_q);
  assign run_next = same ? run_q + 1'b1 : CNT_W'(1);
  assign val_evt  = cw_valid_i && !valid_q && (run_next == CNT_W'(RUN_LEN));
  assign miss     = (cw_code_i != code_q);

  feac_mismatch_window #(
    .WIN_LEN(WIN_LEN),
    .THRESH (THRESH)
  ) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (val_evt),
    .shift_i (cw_valid_i && valid_q),
    .miss_i  (miss),
    .remove_o(rem_evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      code_q  <= '0;
      cand_q  <= '0;
      run_q   <= '0;
    end else if (val_evt) begin
      valid_q <= 1'b1;
      code_q  <= cw_code_i;
      run_q   <= '0;
    end else if (rem_evt) begin
      valid_q <= 1'b0;
      code_q  <= '0;
      run_q   <= '0;
    end else if (cw_valid_i && !valid_q) begin
      cand_q <= cw_code_i;
      run_q  <= run_next;
    end
  end

  assign code_valid_o    = valid_q;
  assign code_o          = code_q;
  assign evt_o.validated = val_evt;
  assign evt_o.removed   = rem_evt;
endmodule

// File: rtl/feac_regs.sv
module feac_regs
  import feac_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic              code_valid_i,
  input  logic [CODE_W-1:0] code_i,
  input  feac_evt_t         evt_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              val_st_o,
  output logic              rem_st_o
);
  logic rd, wr, hit_code, hit_stat;
  logic val_en_q, rem_en_q, val_st_q, rem_st_q;
  logic [DATA_W-1:0] code_word, stat_word, rdata_q;

  assign rd       = bus_en_i && !bus_we_i;
  assign wr       = bus_en_i && bus_we_i;
  assign hit_code = (bus_addr_i == ADDR_CODE);
  assign hit_stat = (bus_addr_i == ADDR_STAT);

  assign code_word = DATA_W'(code_i) << 1;

  always_comb begin
    stat_word             = '0;
    stat_word[BIT_VAL_ST] = val_st_q;
    stat_word[BIT_VAL_EN] = val_en_q;
    stat_word[BIT_REM_ST] = rem_st_q;
    stat_word[BIT_REM_EN] = rem_en_q;
    stat_word[BIT_VALID]  = code_valid_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_en_q <= 1'b0;
      rem_en_q <= 1'b0;
      val_st_q <= 1'b0;
      rem_st_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      // a new event wins over the clear-on-read
      val_st_q <= evt_i.validated || (val_st_q && !(rd && hit_stat));
      rem_st_q <= evt_i.removed   || (rem_st_q && !(rd && hit_stat));
      if (wr && hit_stat) begin
        val_en_q <= bus_wdata_i[BIT_VAL_EN];
        rem_en_q <= bus_wdata_i[BIT_REM_EN];
      end
      if (rd && hit_code)      rdata_q <= code_word;
      else if (rd && hit_stat) rdata_q <= stat_word;
      else                     rdata_q <= '0;
    end
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = (val_st_q && val_en_q) || (rem_st_q && rem_en_q);
  assign val_st_o    = val_st_q;
  assign rem_st_o    = rem_st_q;
endmodule

// File: rtl/feac_rx_validator.sv
module feac_rx_validator
  import feac_pkg::*;
#(
  parameter int unsigned RUN_LEN = 10,
  parameter int unsigned WIN_LEN = 10,
  parameter int unsigned THRESH  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cw_valid_i,
  input  logic [CODE_W-1:0] cw_code_i,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  logic              code_valid;
  logic [CODE_W-1:0] code;
  feac_evt_t         evt;
  logic              val_st, rem_st;

  feac_qualifier #(
    .RUN_LEN(RUN_LEN),
    .WIN_LEN(WIN_LEN),
    .THRESH (THRESH)
  ) u_qual (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cw_valid_i  (cw_valid_i),
    .cw_code_i   (cw_code_i),
    .code_valid_o(code_valid),
    .code_o      (code),
    .evt_o       (evt)
  );

  feac_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_en_i    (bus_en_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .code_valid_i(code_valid),
    .code_i      (code),
    .evt_i       (evt),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o),
    .val_st_o    (val_st),
    .rem_st_o    (rem_st)
  );
endmodule

// File: rtl/feac_rx_validator_chk.sv
module feac_rx_validator_chk
  import feac_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cw_valid_i,
  input logic              bus_en_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              irq_o,
  input logic              code_valid,
  input logic [CODE_W-1:0] code,
  input logic              val_evt,
  input logic              rem_evt,
  input logic              val_st,
  input logic              rem_st
);
  logic rd_stat;
  assign rd_stat = bus_en_i && !bus_we_i && (bus_addr_i == ADDR_STAT);

  assert_validate_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    val_evt |-> !code_valid);
  assert_validate_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    val_evt |=> code_valid && val_st);
  assert_remove_only_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_evt |-> code_valid);
  assert_remove_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_evt |=> !code_valid && code == '0 && rem_st);
  assert_idle_code_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !code_valid |-> code == '0);
  assert_single_event_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({val_evt, rem_evt}));
  assert_read_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat && !val_evt && !rem_evt) |=> !val_st && !rem_st);
  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat && rem_evt) |=> rem_st);
  assert_irq_source_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (val_st || rem_st));
  assert_no_strobe_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cw_valid_i |=> $stable(code_valid) && $stable(code));
endmodule

bind feac_rx_validator feac_rx_validator_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cw_valid_i(cw_valid_i),
  .bus_en_i  (bus_en_i),
  .bus_we_i  (bus_we_i),
  .bus_addr_i(bus_addr_i),
  .irq_o     (irq_o),
  .code_valid(code_valid),
  .code      (code),
  .val_evt   (evt.validated),
  .rem_evt   (evt.removed),
  .val_st    (val_st),
  .rem_st    (rem_st)
);

// File: tb/tb_feac_rx_validator.sv
module tb_feac_rx_validator;
  localparam int CLK_PERIOD = 10;
  localparam int RUN = 10;
  localparam int WIN = 10;
  localparam int THR = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cw_valid = 1'b0;
  logic [5:0] cw_code = '0;
  logic       bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  feac_rx_validator dut (
    .clk_i(clk), .rst_ni(rst_n), .cw_valid_i(cw_valid), .cw_code_i(cw_code),
    .bus_en_i(bus_en), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq)
  );

  int tests = 0, fails = 0;
  bit done = 0;
  logic [7:0] last_rd;

  // reference model state
  bit       m_valid, m_val_st, m_rem_st, m_val_en, m_rem_en;
  logic [5:0] m_code, m_cand;
  int       m_cnt;
  logic [WIN-1:0] m_win;

  function automatic int ones(logic [WIN-1:0] v);
    int n = 0;
    for (int i = 0; i < WIN; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic logic [7:0] m_read(logic [7:0] a);
    if (a == 8'h16) return {1'b0, m_code, 1'b0};
    if (a == 8'h17) return {3'b0, m_valid, m_rem_en, m_rem_st, m_val_en, m_val_st};
    return 8'h00;
  endfunction

  function automatic bit m_irq();
    return (m_val_st && m_val_en) || (m_rem_st && m_rem_en);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic cycle(string tag, bit cw, logic [5:0] code, bit en, bit we,
                       logic [7:0] addr, logic [7:0] wd);
    logic [7:0] exp_rd;
    bit ev_v, ev_r, rd_st;
    exp_rd = (en && !we) ? m_read(addr) : 8'h00;
    cw_valid = cw; cw_code = code;
    bus_en = en; bus_we = we; bus_addr = addr; bus_wdata = wd;
    ev_v = 0; ev_r = 0;
    if (cw) begin
      if (!m_valid) begin
        if (m_cnt > 0 && code == m_cand) m_cnt++;
        else begin m_cand = code; m_cnt = 1; end
        if (m_cnt == RUN) begin
          m_valid = 1; m_code = code; m_win = '0; m_cnt = 0; ev_v = 1;
        end
      end else begin
        m_win = {m_win[WIN-2:0], code != m_code};
        if (ones(m_win) >= THR) begin
          m_valid = 0; m_code = '0; m_win = '0; m_cnt = 0; ev_r = 1;
        end
      end
    end
    rd_st = en && !we && addr == 8'h17;
    m_val_st = ev_v || (m_val_st && !rd_st);
    m_rem_st = ev_r || (m_rem_st && !rd_st);
    if (en && we && addr == 8'h17) begin
      m_val_en = wd[1]; m_rem_en = wd[3];
    end
    @(negedge clk);
    cw_valid = 0; bus_en = 0; bus_we = 0;
    if (en && !we) begin
      chk({tag, " rdata"}, bus_rdata, exp_rd);
      last_rd = bus_rdata;
    end
    chk({tag, " irq"}, {7'b0, irq}, {7'b0, m_irq()});
  endtask

  task automatic send(string tag, logic [5:0] code, int n);
    for (int i = 0; i < n; i++) cycle(tag, 1, code, 0, 0, 8'h00, 8'h00);
  endtask

  task automatic rd_lit(string tag, logic [7:0] addr, logic [7:0] exp);
    cycle(tag, 0, 6'h0, 1, 0, addr, 8'h00);
    chk({tag, " literal"}, last_rd, exp);
  endtask

  task automatic wr(string tag, logic [7:0] addr, logic [7:0] d);
    cycle(tag, 0, 6'h0, 1, 1, addr, d);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    tests++; fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  localparam logic [5:0] CA = 6'h2A, CB = 6'h15, CC = 6'h07, CE = 6'h33, CF = 6'h0C;

  initial begin
    m_valid = 0; m_val_st = 0; m_rem_st = 0; m_val_en = 0; m_rem_en = 0;
    m_code = '0; m_cand = '0; m_cnt = 0; m_win = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {7'b0, irq}, 8'h00);
    rd_lit("R1 stat", 8'h17, 8'h00);
    rd_lit("R1 code", 8'h16, 8'h00);

    // R9 writes touch only enables
    wr("R9", 8'h17, 8'hFF);
    rd_lit("R9 stat", 8'h17, 8'h0A);
    wr("R9", 8'h16, 8'hFF);
    rd_lit("R9 code", 8'h16, 8'h00);

    // R2 nine is not enough, ten validates
    send("R2", CA, 9);
    rd_lit("R2 nine", 8'h17, 8'h0A);
    send("R2", CA, 1);
    chk("R10 irq on validate", {7'b0, irq}, 8'h01);
    rd_lit("R2 stat", 8'h17, 8'h1B);
    rd_lit("R7 cleared", 8'h17, 8'h1A);
    rd_lit("R6 code", 8'h16, 8'h54);

    // R11 repeats raise no new event
    send("R11", CA, 20);
    rd_lit("R11 stat", 8'h17, 8'h1A);

    // R4 sliding window
    send("R4", CB, 2);
    send("R4", CA, 8);
    rd_lit("R4 two miss", 8'h17, 8'h1A);
    send("R4", CC, 2);
    rd_lit("R4 slid out", 8'h17, 8'h1A);
    send("R4", CE, 1);
    rd_lit("R4 removed", 8'h17, 8'h0E);
    rd_lit("R4 code zero", 8'h16, 8'h00);

    // R5 restart after removal
    send("R5", CE, 9);
    rd_lit("R5 nine", 8'h17, 8'h0A);
    send("R5", CE, 1);
    rd_lit("R5 valid", 8'h17, 8'h1B);
    rd_lit("R6 code E", 8'h16, 8'h66);

    // R8 event coincides with status read
    send("R8", CF, 2);
    cycle("R8", 1, CF, 1, 0, 8'h17, 8'h00);
    chk("R8 old value", last_rd, 8'h1A);
    rd_lit("R8 kept", 8'h17, 8'h0E);

    // R3 broken run restarts
    send("R3", CA, 5);
    send("R3", CB, 9);
    rd_lit("R3 nine", 8'h17, 8'h0A);
    send("R3", CB, 1);
    rd_lit("R3 code", 8'h16, 8'h2A);

    // R10 enables gate irq
    wr("R10", 8'h17, 8'h00);
    chk("R10 irq masked", {7'b0, irq}, 8'h00);
    rd_lit("R10 stat", 8'h17, 8'h11);
    wr("R10", 8'h17, 8'h0A);

    // random phase against model
    void'($urandom(32'd2024));
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [5:0] c;
      bit do_cw;
      r = int'($urandom % 100);
      c = (($urandom % 100) < 80) ? CA : ((($urandom % 2) == 0) ? CB : 6'($urandom));
      do_cw = (($urandom % 100) < 60);
      if (r < 10)      cycle("R7 rand", do_cw, c, 1, 0, 8'h17, 8'h00);
      else if (r < 15) cycle("R6 rand", do_cw, c, 1, 0, 8'h16, 8'h00);
      else if (r < 18) cycle("R9 rand", do_cw, c, 1, 1, 8'h17, 8'($urandom));
      else             cycle("R4 rand", do_cw, c, 0, 0, 8'h00, 8'h00);
    end
    rd_lit("R4 final", 8'h17, m_read(8'h17));
    finish_run();
  end
endmodule